// File: doc/BRIEF.md
# Serial DAC Input Latch Logic

This block is the digital front end of a serial-input DAC. A 24-bit command word is shifted in one bit per rising edge of the serial clock, most significant bit first. A rising edge on the latch input decodes the word that currently sits in the shift register. The upper byte selects a target register and the lower 16 bits carry the payload. Two targets exist. The DAC data register sets the output code. The control register sets the output-enable flag.

A rising edge on the clear input forces the output code to zero. It leaves the shift register, the stored DAC value and the control register untouched. A later latch pulse with no serial clock activity in between re-executes the word still held in the shift register. If that word is a DAC data write, the pulse restores the output to its value before the clear. If the last word shifted in was a control write, the pulse only re-applies the control value and the output stays at zero. To make a clear/restore pair work, the host must therefore shift a DAC data write last, before it pulses the clear input.

All serial and pulse inputs are treated as synchronous to the system clock. Each passes through a short register chain before edge detection, so every action lands a fixed few cycles after its input rises.

Top module: `serial_dac_front`

## Requirements
- R1: After reset the output code is 0x0000 and the output-enable flag is 0.
- R2: Each rising serial clock edge shifts the serial data bit into bit 0 of a 24-bit register and moves the older bits up, so the register is sent MSB first. On a rising latch edge, a word whose bits 23:16 equal 0x01 copies bits 15:0 to the output code.
- R3: On a rising latch edge, a word whose bits 23:16 equal 0x55 loads bits 15:0 into the control register. Control bit 0 drives the output-enable flag. The output code is left unchanged.
- R4: On a rising latch edge, a word with any other address in bits 23:16 changes neither the output code nor the output-enable flag.
- R5: A rising clear edge drives the output code to 0x0000 and leaves the output-enable flag unchanged.
- R6: A latch edge after a clear, with no serial clock edge in between, restores the pre-clear output code when the held word is a DAC data write.
- R7: When the held word is a control write, a latch edge after a clear applies the control value again and the output code stays 0x0000.
- R8: Clear changes neither the shift register nor the stored DAC value. A replay after any number of clears reproduces the same code.
- R9: When latch and clear rise in the same cycle, clear wins and the output code reads 0x0000. A later latch edge alone applies the held word.
- R10: When more than 24 bits are shifted in, only the last 24 bits decide the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, acted on at its rising edge |
| ser_din | input | 1 | Serial data bit, MSB first |
| latch_pulse | input | 1 | Rising edge executes the held word |
| clear_pulse | input | 1 | Rising edge forces the output code to zero |
| dac_code | output | 16 | Output code to the converter |
| drive_en | output | 1 | Output-enable flag from control bit 0 |

## Verification
The hardest situation to reach from the ports is a replay after a clear. The serial clock must stay idle between the clear and the latch edge, so the result depends only on which word was shifted in last. The stimulus walks both orders. In one, a DAC write is shifted last, then clear, then a bare latch pulse. In the other, a control write follows the DAC write, so the same pulse pair must leave the output at zero. Further cases cover a word longer than 24 bits, latch and clear rising in the same cycle, and repeated clears before one replay.

// File: rtl/dac_front_pkg.sv
// Package: shared widths and the command word layout for the serial DAC front end.
package dac_front_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int WORD_W = ADDR_W + DATA_W;

    // Command word: address in the upper byte, payload in the lower bits.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_word_t;
endpackage

// File: rtl/dfe_sync.sv
// Module: dfe_sync
// Carries a single-bit input through STAGES flops. The input is assumed
// synchronous to clk. The chain gives a fixed, known delay and a clean
// registered level for the edge detectors. STAGES must be at least 1.
module dfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first flop samples the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[0] <= 1'b0;
                    else        st[0] <= d;
                end
            end else begin : g_next
                // Purpose: later flops pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) st[g] <= 1'b0;
                    else        st[g] <= st[g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/dfe_rise.sv
// Module: dfe_rise
// Turns a registered level into a one-cycle pulse on its 0->1 transition.
// Assumes the level comes from a flop, so the pulse is glitch free.
module dfe_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/dfe_shifter.sv
// Module: dfe_shifter
// Serial-in shift register for command words, MSB first. It shifts only
// when shift_en pulses. It holds its contents otherwise, including
// across clear.
module dfe_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    // Purpose: move older bits up and insert the new bit at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WIDTH-2:0], bit_in};
    end
endmodule

// File: rtl/dfe_regs.sv
// Module: dfe_regs
// Decodes the held word on a latch pulse and keeps the DAC data and
// control registers. A clear pulse sets a zero-override flag and touches
// no stored value. A DAC data latch without a simultaneous clear drops
// the override. Clear has priority when both pulse together.
module dfe_regs
    import dac_front_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DAC_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h55,
    parameter int                EN_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_go,
    input  logic              clear_go,
    input  cmd_word_t         held,
    output logic [DATA_W-1:0] code,
    output logic              enable
);
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              zeroed_q;
    logic              hit_dac;
    logic              hit_ctrl;

    assign hit_dac  = latch_go && (held.addr == DAC_ADDR);
    assign hit_ctrl = latch_go && (held.addr == CTRL_ADDR);

    // Purpose: DAC data register, written only by a DAC data latch.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (hit_dac) data_q <= held.data;
    end

    // Purpose: control register, written only by a control latch.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctrl_q <= '0;
        else if (hit_ctrl) ctrl_q <= held.data;
    end

    // Purpose: zero-override flag; clear sets it and wins, a DAC latch drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)        zeroed_q <= 1'b0;
        else if (clear_go) zeroed_q <= 1'b1;
        else if (hit_dac)  zeroed_q <= 1'b0;
    end

    assign code   = zeroed_q ? '0 : data_q;
    assign enable = ctrl_q[EN_BIT];
endmodule

// File: rtl/serial_dac_front.sv
// Module: serial_dac_front (top)
// Digital front end of a serial DAC. It aligns the serial clock, data,
// latch and clear inputs through equal register chains. It detects
// their rising edges, shifts command words in, and executes the held
// word on latch. All inputs are assumed synchronous to clk.
module serial_dac_front
    import dac_front_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DAC_ADDR    = 8'h01,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h55,
    parameter int                EN_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              latch_pulse,
    input  logic              clear_pulse,
    output logic [DATA_W-1:0] dac_code,
    output logic              drive_en
);
    localparam int N_PULSE = 3;

    logic [N_PULSE-1:0] raw_in;
    logic [N_PULSE-1:0] lvl_s;
    logic [N_PULSE-1:0] rise_s;
    logic               din_s;
    logic               sclk_rise;
    logic               latch_rise;
    logic               clr_rise;
    logic [WORD_W-1:0]  shreg;

    assign raw_in = {clear_pulse, latch_pulse, ser_clk};

    genvar k;
    generate
        for (k = 0; k < N_PULSE; k++) begin : g_pulse
            dfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .d(raw_in[k]), .q(lvl_s[k])
            );
            dfe_rise u_rise (
                .clk(clk), .rst_n(rst_n), .lvl(lvl_s[k]), .rise(rise_s[k])
            );
        end
    endgenerate

    // Data bit uses the same delay so it lines up with the clock edge.
    dfe_sync #(.STAGES(SYNC_STAGES)) u_din_sync (
        .clk(clk), .rst_n(rst_n), .d(ser_din), .q(din_s)
    );

    assign sclk_rise  = rise_s[0];
    assign latch_rise = rise_s[1];
    assign clr_rise   = rise_s[2];

    dfe_shifter #(.WIDTH(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise),
        .bit_in(din_s), .word(shreg)
    );

    dfe_regs #(
        .DAC_ADDR(DAC_ADDR), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .latch_go(latch_rise), .clear_go(clr_rise),
        .held(cmd_word_t'(shreg)), .code(dac_code), .enable(drive_en)
    );
endmodule

// File: rtl/serial_dac_front_chk.sv
// Module: serial_dac_front_chk
// Property checker bound to serial_dac_front. It watches the edge pulses,
// the shift register and the outputs.
module serial_dac_front_chk
    import dac_front_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DAC_ADDR  = 8'h01,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_rise,
    input logic              latch_rise,
    input logic              clr_rise,
    input logic [WORD_W-1:0] shreg,
    input logic [DATA_W-1:0] dac_code,
    input logic              drive_en
);
    logic [ADDR_W-1:0] adr;
    assign adr = shreg[WORD_W-1:DATA_W];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && !drive_en));

    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));

    assert_dac_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !clr_rise && adr == DAC_ADDR)
        |=> dac_code == $past(shreg[DATA_W-1:0]));

    assert_ctrl_keeps_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !clr_rise && adr == CTRL_ADDR) |=> $stable(dac_code));

    assert_other_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !clr_rise && adr != DAC_ADDR && adr != CTRL_ADDR)
        |=> ($stable(dac_code) && $stable(drive_en)));

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> dac_code == '0);

    assert_clear_keeps_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !latch_rise) |=> $stable(drive_en));

    assert_shift_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(shreg));
endmodule

bind serial_dac_front serial_dac_front_chk #(
    .DAC_ADDR(DAC_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .latch_rise(latch_rise),
    .clr_rise(clr_rise), .shreg(shreg), .dac_code(dac_code), .drive_en(drive_en)
);

// File: tb/serial_dac_front_tb.sv
module serial_dac_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic        latch_pulse = 1'b0;
    logic        clear_pulse = 1'b0;
    logic [15:0] dac_code;
    logic        drive_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] code;
        logic        en;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    bit   chk_req = 1'b0;

    always #2.5 clk = ~clk;

    serial_dac_front u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .latch_pulse(latch_pulse), .clear_pulse(clear_pulse),
        .dac_code(dac_code), .drive_en(drive_en)
    );

    // Monitor: pops an expected item when asked and compares it with the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (chk_req && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (dac_code !== e.code || drive_en !== e.en) begin
                    n_bad++;
                    $display("FAIL %s: code=%h en=%b expected code=%h en=%b",
                             e.tag, dac_code, drive_en, e.code, e.en);
                end
                chk_req = 1'b0;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: let the pipeline settle, queue the expectation, hand it to the monitor.
    task automatic expect_out(input logic [15:0] code, input logic en, input string tag);
        exp_t e;
        wait_cyc(8);
        e.code = code; e.en = en; e.tag = tag;
        exp_q.push_back(e);
        chk_req = 1'b1;
        while (chk_req) @(posedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i];
            ser_clk = 1'b0;
            wait_cyc(2);
            ser_clk = 1'b1;
            wait_cyc(2);
        end
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_word(input logic [7:0] adr, input logic [15:0] dat);
        shift_bits({8'h00, adr, dat}, 24);
    endtask

    task automatic pulse_latch();
        latch_pulse = 1'b1; wait_cyc(2); latch_pulse = 1'b0; wait_cyc(2);
    endtask

    task automatic pulse_clear();
        clear_pulse = 1'b1; wait_cyc(2); clear_pulse = 1'b0; wait_cyc(2);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        expect_out(16'h0000, 1'b0, "R1 reset state");

        send_word(8'h01, 16'h1234); pulse_latch();
        expect_out(16'h1234, 1'b0, "R2 DAC write");

        send_word(8'h55, 16'h0001); pulse_latch();
        expect_out(16'h1234, 1'b1, "R3 control enable");

        send_word(8'h01, 16'hBEEF); pulse_latch();
        expect_out(16'hBEEF, 1'b1, "R2 second DAC write");

        pulse_clear();
        expect_out(16'h0000, 1'b1, "R5 clear zeroes code, keeps enable");

        pulse_latch();
        expect_out(16'hBEEF, 1'b1, "R6 replay restores");

        pulse_clear(); pulse_clear(); pulse_clear();
        pulse_latch();
        expect_out(16'hBEEF, 1'b1, "R8 replay after repeated clears");

        send_word(8'h55, 16'h0001); pulse_latch();
        pulse_clear(); pulse_latch();
        expect_out(16'h0000, 1'b1, "R7 control word held, stays zero");

        send_word(8'h55, 16'h0000); pulse_latch();
        expect_out(16'h0000, 1'b0, "R7 control replay updates enable only");

        send_word(8'h01, 16'hA5A5); pulse_latch();
        expect_out(16'hA5A5, 1'b0, "R2 DAC write clears override");

        send_word(8'h02, 16'hFFFF); pulse_latch();
        expect_out(16'hA5A5, 1'b0, "R4 address 0x02 ignored");

        send_word(8'h00, 16'h0001); pulse_latch();
        expect_out(16'hA5A5, 1'b0, "R4 address 0x00 ignored");

        shift_bits({8'hFF, 8'h01, 16'h0F0F}, 32); pulse_latch();
        expect_out(16'h0F0F, 1'b0, "R10 only last 24 bits count");

        send_word(8'h01, 16'h7777);
        latch_pulse = 1'b1; clear_pulse = 1'b1;
        wait_cyc(2);
        latch_pulse = 1'b0; clear_pulse = 1'b0;
        wait_cyc(2);
        expect_out(16'h0000, 1'b0, "R9 clear wins over latch");

        pulse_latch();
        expect_out(16'h7777, 1'b0, "R9 later latch applies held word");

        send_word(8'h55, 16'h0001); pulse_latch();
        pulse_clear();
        expect_out(16'h0000, 1'b1, "R5 clear with enable set");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule